// File: doc/BRIEF.md
# Dual-Modulus Feedback Divider Controller

This block divides a fast input clock by a programmable integer and steers the modulus line of a P/P+1 prescaler. The prescaler is part of the block and is built as a counter. A swallow counter and a main counter work in lockstep with it. At the start of every division cycle the prescaler divides by P+1 until the swallow counter runs out, and then by P for the rest of the cycle. The main counter ends the cycle. The division ratio is N = B·P + A. At the end of each cycle the block emits one pulse, one input clock wide.

Software presents a prescaler select, a swallow value A (6 bits) and a main value B (13 bits), and strobes a load input. A valid setting is held pending and becomes active only at the boundary between two division cycles, so no output period is ever cut short. A setting with B below A, or with B equal to zero, is rejected. It raises a one-clock error flag and leaves the running setting untouched.

Top module: `dmod_div_top`

## Requirements
- R1: The interval between two consecutive `div_out` pulses is B·P + A input clocks, where P is 8, 16, 32 or 64 for `psel_in` codes 0, 1, 2 and 3.
- R2: When the active A is 0, `mod_ctl` stays low for the whole cycle.
- R3: In each cycle `mod_ctl` is high for exactly A·(P+1) clocks, all at the start of the cycle, and low for the rest.
- R4: `div_out` is high for exactly one clock per cycle, on the last clock of the cycle.
- R5: A valid load changes nothing in the cycle that is running. The new A, B and P govern the cycle that follows the next pulse.
- R6: A load with B < A or B = 0 raises `cfg_bad` for one clock, starting at the clock edge that samples the load, and the running setting is kept. A valid load leaves `cfg_bad` low.
- R7: After reset the outputs are low and the active setting is P=8, A=0, B=1, which gives an interval of 8 clocks.
- R8: The extreme swallow value A=63 (with B=63) divides correctly in every prescaler mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock (the stream to divide) |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Strobe that captures psel_in, a_in and b_in |
| psel_in | input | 2 | Prescaler select: 0→8/9, 1→16/17, 2→32/33, 3→64/65 |
| a_in | input | 6 | Swallow count A |
| b_in | input | 13 | Main count B |
| mod_ctl | output | 1 | High: prescaler divides by P+1 |
| div_out | output | 1 | One-clock pulse at the end of each cycle |
| cfg_bad | output | 1 | One-clock flag for a rejected load |

## Verification
Directed settings cover every prescaler mode with A=0, which tells the pure divide-by-P path apart from swallowing, and with A=B=63, the case where the whole cycle runs at P+1. A fixed-seed random set of settings with B close to A checks the interaction of the two counters in every mode. Loads are issued in the middle of a cycle, so the interval that ends at the next pulse must still show the old ratio and the interval after it the new one. Rejected settings must leave the following intervals unchanged.

// File: rtl/dmod_pkg.sv
package dmod_pkg;
  localparam int A_W  = 6;
  localparam int B_W  = 13;
  localparam int PS_W = 2;
  localparam int PC_W = 7;

  typedef struct packed {
    logic [PS_W-1:0] ps;
    logic [A_W-1:0]  a;
    logic [B_W-1:0]  b;
  } dmod_cfg_t;

  // Base modulus P for a select code: 8 shifted left by the code
  function automatic logic [PC_W-1:0] base_mod(input logic [PS_W-1:0] ps);
    return PC_W'(8) << ps;
  endfunction

  // A setting is usable when the main count covers the swallow count
  function automatic logic cfg_usable(input logic [A_W-1:0] a, input logic [B_W-1:0] b);
    return (b != '0) && (b >= B_W'(a));
  endfunction
endpackage

// File: rtl/dmod_cfg.sv
module dmod_cfg
  import dmod_pkg::*;
#(
  parameter logic [PS_W-1:0] DEF_PS = '0,
  parameter logic [A_W-1:0]  DEF_A  = '0,
  parameter logic [B_W-1:0]  DEF_B  = B_W'(1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [PS_W-1:0] ps_in,
  input  logic [A_W-1:0]  a_in,
  input  logic [B_W-1:0]  b_in,
  input  logic            cycle_end,
  output dmod_cfg_t       act,
  output dmod_cfg_t       nxt,
  output logic            bad
);
  localparam dmod_cfg_t DEF_CFG = '{ps: DEF_PS, a: DEF_A, b: DEF_B};

  dmod_cfg_t pend;
  logic      pend_v;
  logic      ok_now;

  assign ok_now = cfg_usable(a_in, b_in);
  assign nxt    = pend_v ? pend : act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act    <= DEF_CFG;
      pend   <= DEF_CFG;
      pend_v <= 1'b0;
      bad    <= 1'b0;
    end else begin
      bad <= load && !ok_now;
      if (cycle_end) begin
        act <= nxt;
      end
      if (load && ok_now) begin
        pend   <= '{ps: ps_in, a: a_in, b: b_in};
        pend_v <= 1'b1;
      end else if (cycle_end) begin
        pend_v <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dmod_prescaler.sv
module dmod_prescaler
  import dmod_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PS_W-1:0] ps,
  input  logic            mod_hi,
  output logic            pres_tc
);
  logic [PC_W-1:0] pcnt;
  logic [PC_W-1:0] last;

  assign last    = base_mod(ps) - PC_W'(1) + PC_W'(mod_hi);
  assign pres_tc = (pcnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pcnt <= '0;
    else if (pres_tc) pcnt <= '0;
    else              pcnt <= pcnt + PC_W'(1);
  end
endmodule

// File: rtl/dmod_counters.sv
module dmod_counters
  import dmod_pkg::*;
#(
  parameter logic [A_W-1:0] DEF_A = '0,
  parameter logic [B_W-1:0] DEF_B = B_W'(1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pres_tc,
  input  logic [A_W-1:0] nxt_a,
  input  logic [B_W-1:0] nxt_b,
  output logic           mod_hi,
  output logic           term
);
  logic [A_W-1:0] a_left;
  logic [B_W-1:0] b_left;

  assign mod_hi = (a_left != '0);
  assign term   = pres_tc && (b_left == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_left <= DEF_A;
      b_left <= DEF_B - B_W'(1);
    end else if (term) begin
      a_left <= nxt_a;
      b_left <= nxt_b - B_W'(1);
    end else if (pres_tc) begin
      b_left <= b_left - B_W'(1);
      if (mod_hi) a_left <= a_left - A_W'(1);
    end
  end
endmodule

// File: rtl/dmod_div_top.sv
module dmod_div_top
  import dmod_pkg::*;
#(
  parameter logic [PS_W-1:0] DEF_PS = '0,
  parameter logic [A_W-1:0]  DEF_A  = '0,
  parameter logic [B_W-1:0]  DEF_B  = B_W'(1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [1:0]      psel_in,
  input  logic [5:0]      a_in,
  input  logic [12:0]     b_in,
  output logic            mod_ctl,
  output logic            div_out,
  output logic            cfg_bad
);
  dmod_cfg_t act, nxt;
  logic      pres_tc;
  logic      term;
  // Named internal events for the checker
  logic [A_W-1:0]  act_a;
  logic [B_W-1:0]  act_b;
  logic [PS_W-1:0] act_ps;

  assign act_a  = act.a;
  assign act_b  = act.b;
  assign act_ps = act.ps;

  dmod_cfg #(.DEF_PS(DEF_PS), .DEF_A(DEF_A), .DEF_B(DEF_B)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(load), .ps_in(psel_in), .a_in(a_in),
    .b_in(b_in), .cycle_end(term), .act(act), .nxt(nxt), .bad(cfg_bad)
  );

  dmod_prescaler u_pres (
    .clk(clk), .rst_n(rst_n), .ps(act.ps), .mod_hi(mod_ctl), .pres_tc(pres_tc)
  );

  dmod_counters #(.DEF_A(DEF_A), .DEF_B(DEF_B)) u_cnt (
    .clk(clk), .rst_n(rst_n), .pres_tc(pres_tc), .nxt_a(nxt.a), .nxt_b(nxt.b),
    .mod_hi(mod_ctl), .term(term)
  );

  assign div_out = term;
endmodule

// File: rtl/dmod_div_chk.sv
module dmod_div_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        load,
  input logic [5:0]  a_in,
  input logic [12:0] b_in,
  input logic        mod_ctl,
  input logic        div_out,
  input logic        cfg_bad,
  input logic [5:0]  act_a,
  input logic [12:0] act_b,
  input logic [1:0]  act_ps
);
  p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    div_out |=> !div_out);

  p_no_swallow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (act_a == 6'd0) |-> !mod_ctl);

  p_mod_prefix_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mod_ctl && !div_out) |=> !mod_ctl);

  p_hold_midcycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !div_out |=> ($stable(act_a) && $stable(act_b) && $stable(act_ps)));

  p_reject_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (load && ((b_in < 13'(a_in)) || (b_in == 13'd0))) |=> cfg_bad);

  p_accept_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (load && (b_in >= 13'(a_in)) && (b_in != 13'd0)) |=> !cfg_bad);

  p_active_sane_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (act_b >= 13'(act_a)) && (act_b != 13'd0));
endmodule

bind dmod_div_top dmod_div_chk u_chk (
  .clk(clk), .rst_n(rst_n), .load(load), .a_in(a_in), .b_in(b_in),
  .mod_ctl(mod_ctl), .div_out(div_out), .cfg_bad(cfg_bad),
  .act_a(act_a), .act_b(act_b), .act_ps(act_ps)
);

// File: tb/dmod_div_top_bench.sv
module dmod_div_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0;
  logic [1:0]  psel_in = '0;
  logic [5:0]  a_in = '0;
  logic [12:0] b_in = '0;
  logic        mod_ctl, div_out, cfg_bad;

  int checks = 0;
  int failures = 0;
  int cur_n, cur_m;

  always #10 clk = ~clk;

  dmod_div_top u_dmod_div_top (
    .clk(clk), .rst_n(rst_n), .load(load), .psel_in(psel_in), .a_in(a_in),
    .b_in(b_in), .mod_ctl(mod_ctl), .div_out(div_out), .cfg_bad(cfg_bad)
  );

  function automatic int ratio(input int ps, input int a, input int b);
    return (b << (ps + 3)) + a;
  endfunction

  function automatic int swallow_clks(input int ps, input int a);
    return a * ((1 << (ps + 3)) + 1);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called at a negedge where div_out is high; counts one full cycle.
  task automatic run_cycle(input bit do_ld, input int ps, input int a, input int b,
                           output int n, output int mh, output int bad, output int wide);
    bit ld_live = 0;
    n = 0; mh = 0; bad = -1; wide = 0;
    do begin
      @(negedge clk);
      n++;
      if (ld_live) begin bad = cfg_bad; load = 1'b0; ld_live = 0; end
      if (n == 1 && div_out) wide = 1;
      if (mod_ctl) mh++;
      if (do_ld && n == 2) begin
        psel_in = 2'(ps); a_in = 6'(a); b_in = 13'(b); load = 1'b1; ld_live = 1;
      end
    end while (!div_out && n < 20000);
  endtask

  task automatic sync_pulse();
    int g = 0;
    do begin @(negedge clk); g++; end while (!div_out && g < 20000);
  endtask

  // Load a setting mid-cycle, then check the old and the new ratio.
  task automatic apply(input int ps, input int a, input int b, input string tag);
    int n, mh, bad, wide;
    bit ok;
    int ops, oa, ob;
    ok = (b != 0) && (b >= a);
    run_cycle(1, ps, a, b, n, mh, bad, wide);
    chk(n == cur_n, "R5 old ratio kept in running cycle", n, cur_n);
    chk(bad == (ok ? 0 : 1), "R6 cfg_bad after load", bad, ok ? 0 : 1);
    run_cycle(0, 0, 0, 0, n, mh, bad, wide);
    if (ok) begin
      cur_n = ratio(ps, a, b);
      cur_m = swallow_clks(ps, a);
    end
    chk(n == cur_n, {tag, " R1 division ratio"}, n, cur_n);
    chk(mh == cur_m, {tag, " R3 mod_ctl high clocks"}, mh, cur_m);
    chk(wide == 0, "R4 pulse one clock wide", wide, 0);
    if (ok && a == 0) chk(mh == 0, "R2 no swallow when A=0", mh, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n, mh, bad, wide;
    int seed;
    seed = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    chk(div_out == 0, "R7 div_out low in reset", div_out, 0);
    chk(mod_ctl == 0, "R7 mod_ctl low in reset", mod_ctl, 0);
    chk(cfg_bad == 0, "R7 cfg_bad low in reset", cfg_bad, 0);
    rst_n = 1'b1;
    sync_pulse();
    run_cycle(0, 0, 0, 0, n, mh, bad, wide);
    chk(n == 8, "R7 default ratio", n, 8);
    cur_n = 8; cur_m = 0;

    for (int ps = 0; ps < 4; ps++) begin
      apply(ps, 0, 3, "R2 A=0");
      apply(ps, 63, 63, "R8 A=B=63");
      apply(ps, 5, 11, "mid");
    end

    apply(1, 10, 4, "R6 B<A rejected");
    apply(2, 0, 0, "R6 B=0 rejected");
    apply(0, 1, 1, "A=B=1");

    for (int k = 0; k < 10; k++) begin
      int ps, a, b;
      ps = int'($urandom_range(3, 0));
      a  = int'($urandom_range(40, 0));
      b  = a + int'($urandom_range(8, 0));
      if (b == 0) b = 1;
      apply(ps, a, b, "random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule